// File: doc/BRIEF.md
# Binary Pixel Stream Coordinate Decoder

This block sits behind a binary contrast imager that reads out a frame row by row. For each changed pixel the sensor places one byte on its data bus, holding a sign bit and a column number, and raises a write strobe. A separate strobe marks the move to the next row. The row number never appears on the bus. The decoder recovers it by counting row strobes since the frame began. It then stores a signed (row, column) record for every accepted pixel in a local buffer.

Records are gathered into groups before each buffer write, so the storage side can be slower than the peak strobe rate. A short group left at the end of the frame is written as a partial group. The block counts stored pixels and stops that count at the buffer's capacity. It keeps a sticky flag when pixels are lost, and it gives a one-cycle pulse when the frame is complete. A byte-wide read port then returns the stored records.

Top module: `pixstream_decoder`

## Requirements
- R1: The input byte carries the sign in bit 7 and the column in bits 6:0. Each stored record is {sign, row, column}: the column in the low COL_W bits, the row in the next log2(ROWS) bits, and the sign directly above them. A record is read as two bytes from byte address 2*index (low byte) and 2*index+1 (high byte), zero-padded to 16 bits.
- R2: The write and row strobes each pass through a two-flip-flop synchroniser. Each rising edge of a strobe counts as exactly one event, however long the strobe stays high.
- R3: A pixel's row equals the number of row strobes seen since the last frame start, counting only those seen before the pixel.
- R4: A frame ends on its ROWS-th row strobe. The done output is high for exactly one cycle, on the cycle after that strobe is processed. Strobes that arrive after the end of the frame and before the next frame start are ignored.
- R5: Records reach the buffer PACK at a time. At the end of a frame, a partial group of 1 to PACK-1 records is flushed, so every accepted pixel can be read back in arrival order.
- R6: The pixel count equals the number of records stored in the current frame. It saturates at DEPTH.
- R7: Pixels that arrive once DEPTH records are held are dropped and set a sticky overflow flag. Records already stored are not changed.
- R8: A frame start pulse clears the row count, the pixel count, the overflow flag and the partial group. It also re-enables capture.
- R9: Read data reflects the byte address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Clears per-frame state and begins capture |
| px_bus | input | 8 | Sensor data byte: sign and column |
| px_wr | input | 1 | Asynchronous pixel write strobe |
| px_eor | input | 1 | Asynchronous end-of-row strobe |
| rd_addr | input | $clog2(DEPTH)+1 | Byte address into the record buffer |
| rd_data | output | 8 | Registered read byte |
| px_count | output | $clog2(DEPTH+1) | Records stored this frame |
| overflow | output | 1 | Sticky: a pixel was dropped |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the decoder with four rows, a group size of four and an eight-record buffer, while keeping the full 7-bit column. With these values, an entire frame, the buffer-full boundary, a dropped pixel and both the flushed and unflushed end-of-frame cases all fit in a few short sequences. The bench reads back every stored record and compares it with a value it builds from the row and column it sent. The sequences cover pixels in several rows, an empty row, a held strobe, strobes sent after the frame is done, and frames that end exactly on a full group.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
   localparam int unsigned BUS_W = 8;
   localparam int unsigned RD_W  = 16;

   function automatic int unsigned log2c(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction
endpackage

// File: rtl/pxd_strobe_sync.sv
module pxd_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic rise_ev
);
   logic [STAGES:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pxd_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], strobe_in};
   end

   assign rise_ev = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pxd_packer.sv
module pxd_packer #(
   parameter int unsigned ROWS  = 64,
   parameter int unsigned COL_W = 7,
   parameter int unsigned PACK  = 4,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned RBW   = pxd_pkg::log2c(ROWS),
   localparam int unsigned REC_W = 1 + RBW + COL_W,
   localparam int unsigned LW    = pxd_pkg::log2c(PACK),
   localparam int unsigned WORDS = DEPTH / PACK,
   localparam int unsigned WAW   = pxd_pkg::log2c(WORDS),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    pix_ev,
   input  logic [7:0]              pix_byte,
   input  logic                    eor_ev,
   output logic                    wr_en,
   output logic [WAW-1:0]          wr_word,
   output logic [PACK-1:0]         wr_mask,
   output logic [PACK*REC_W-1:0]   wr_recs,
   output logic [CW-1:0]           count,
   output logic                    ovf,
   output logic                    done
);
   localparam logic [CW-1:0]  FULL     = CW'(DEPTH);
   localparam logic [RBW-1:0] LAST_ROW = RBW'(ROWS - 1);

   logic [REC_W-1:0] grp_q [PACK];
   logic [RBW-1:0]   row_q;
   logic             live_q;
   logic [LW-1:0]    lane;
   logic [LW:0]      fill;
   logic             accept, last_eor;
   logic [REC_W-1:0] rec;

   assign lane     = count[LW-1:0];
   assign accept   = live_q && pix_ev && (count != FULL);
   assign last_eor = live_q && eor_ev && (row_q == LAST_ROW);
   assign rec      = {pix_byte[7], row_q, pix_byte[COL_W-1:0]};
   assign fill     = accept ? ({1'b0, lane} + 1'b1) : {1'b0, lane};

   assign wr_en   = (accept && (lane == LW'(PACK - 1))) || (last_eor && (fill != '0));
   assign wr_word = WAW'(count >> LW);

   genvar g;
   generate
      for (g = 0; g < PACK; g++) begin : g_lane
         assign wr_mask[g] = (LW + 1)'(g) < fill;
         assign wr_recs[g*REC_W +: REC_W] =
            (accept && (lane == LW'(g))) ? rec : grp_q[g];
         always_ff @(posedge clk) begin
            if (accept && (lane == LW'(g))) grp_q[g] <= rec;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         live_q <= 1'b1;
         count  <= '0;
         ovf    <= 1'b0;
         done   <= 1'b0;
      end else if (clr) begin
         row_q  <= '0;
         live_q <= 1'b1;
         count  <= '0;
         ovf    <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= last_eor;
         if (accept) count <= count + 1'b1;
         if (live_q && pix_ev && (count == FULL)) ovf <= 1'b1;
         if (live_q && eor_ev) begin
            if (last_eor) live_q <= 1'b0;
            else          row_q  <= row_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pxd_store.sv
module pxd_store #(
   parameter int unsigned REC_W = 14,
   parameter int unsigned PACK  = 4,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned LW    = pxd_pkg::log2c(PACK),
   localparam int unsigned WORDS = DEPTH / PACK,
   localparam int unsigned WAW   = pxd_pkg::log2c(WORDS),
   localparam int unsigned IW    = pxd_pkg::log2c(DEPTH),
   localparam int unsigned AW    = IW + 1
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [WAW-1:0]        wr_word,
   input  logic [PACK-1:0]       wr_mask,
   input  logic [PACK*REC_W-1:0] wr_recs,
   input  logic [AW-1:0]         rd_addr,
   output logic [7:0]            rd_data
);
   logic [REC_W-1:0] mem [WORDS][PACK];
   logic [IW-1:0]    idx;
   logic [WAW-1:0]   rword;
   logic [LW-1:0]    rlane;
   logic [pxd_pkg::RD_W-1:0] wide;

   assign idx   = rd_addr[AW-1:1];
   assign rword = WAW'(idx >> LW);
   assign rlane = idx[LW-1:0];
   assign wide  = pxd_pkg::RD_W'(mem[rword][rlane]);

   genvar g;
   generate
      for (g = 0; g < PACK; g++) begin : g_wr
         always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) mem[wr_word][g] <= wr_recs[g*REC_W +: REC_W];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      rd_data <= rd_addr[0] ? wide[15:8] : wide[7:0];
   end
endmodule

// File: rtl/pixstream_decoder.sv
module pixstream_decoder #(
   parameter int unsigned ROWS  = 64,
   parameter int unsigned COL_W = 7,
   parameter int unsigned PACK  = 4,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned RBW   = pxd_pkg::log2c(ROWS),
   localparam int unsigned REC_W = 1 + RBW + COL_W,
   localparam int unsigned WORDS = DEPTH / PACK,
   localparam int unsigned WAW   = pxd_pkg::log2c(WORDS),
   localparam int unsigned AW    = pxd_pkg::log2c(DEPTH) + 1,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic [7:0]    px_bus,
   input  logic          px_wr,
   input  logic          px_eor,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [CW-1:0] px_count,
   output logic          overflow,
   output logic          done
);
   generate
      if (COL_W != 7)                      begin : g_e0 $error("COL_W must be 7"); end
      if ((ROWS & (ROWS - 1)) != 0 || ROWS < 2) begin : g_e1 $error("ROWS must be a power of two"); end
      if ((PACK & (PACK - 1)) != 0 || PACK < 2) begin : g_e2 $error("PACK must be a power of two"); end
      if (DEPTH % PACK != 0 || DEPTH < 2*PACK)  begin : g_e3 $error("DEPTH must hold two groups"); end
      if (REC_W > pxd_pkg::RD_W)           begin : g_e4 $error("record wider than read word"); end
   endgenerate

   logic pix_ev, eor_ev, wr_en;
   logic [WAW-1:0]        wr_word;
   logic [PACK-1:0]       wr_mask;
   logic [PACK*REC_W-1:0] wr_recs;

   pxd_strobe_sync #(.STAGES(2)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .strobe_in(px_wr), .rise_ev(pix_ev));
   pxd_strobe_sync #(.STAGES(2)) u_eor_sync (
      .clk(clk), .rst_n(rst_n), .strobe_in(px_eor), .rise_ev(eor_ev));

   pxd_packer #(.ROWS(ROWS), .COL_W(COL_W), .PACK(PACK), .DEPTH(DEPTH)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(frame_start), .pix_ev(pix_ev), .pix_byte(px_bus),
      .eor_ev(eor_ev), .wr_en(wr_en), .wr_word(wr_word), .wr_mask(wr_mask),
      .wr_recs(wr_recs), .count(px_count), .ovf(overflow), .done(done));

   pxd_store #(.REC_W(REC_W), .PACK(PACK), .DEPTH(DEPTH)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_word(wr_word), .wr_mask(wr_mask),
      .wr_recs(wr_recs), .rd_addr(rd_addr), .rd_data(rd_data));
endmodule

// File: rtl/pixstream_decoder_chk.sv
module pixstream_decoder_chk #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_start,
   input logic [CW-1:0] px_count,
   input logic          overflow,
   input logic          done
);
   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      px_count <= CW'(DEPTH)) else $error("count above capacity"); // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> (px_count == $past(px_count) || px_count == $past(px_count) + 1'b1))
      else $error("count jumped"); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !frame_start |=> overflow) else $error("overflow cleared"); // R7
   AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> px_count == CW'(DEPTH)) else $error("overflow before full"); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R4
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (px_count == '0 && !overflow && !done)) else $error("start did not clear"); // R8
endmodule

bind pixstream_decoder pixstream_decoder_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .px_count(px_count), .overflow(overflow), .done(done));

// File: tb/pixstream_decoder_test.sv
module pixstream_decoder_test;
   localparam int ROWS = 4, PACK = 4, DEPTH = 8, AW = 4, CW = 4;

   logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
   logic [7:0] px_bus = '0;
   logic px_wr = 1'b0, px_eor = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [CW-1:0] px_count;
   logic overflow, done;

   int n_chk = 0, n_bad = 0, done_hits = 0;
   int exp_rec [16];
   int n_exp;
   int cur_row;

   always #5 clk = ~clk;

   pixstream_decoder #(.ROWS(ROWS), .COL_W(7), .PACK(PACK), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .px_bus(px_bus),
      .px_wr(px_wr), .px_eor(px_eor), .rd_addr(rd_addr), .rd_data(rd_data),
      .px_count(px_count), .overflow(overflow), .done(done));

   always @(posedge clk) if (rst_n && done) done_hits <= done_hits + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_px(input int sgn, input int col, input int hold);
      @(negedge clk);
      px_bus = 8'((sgn << 7) | col);
      px_wr = 1'b1;
      idle(hold);
      px_wr = 1'b0;
      idle(3);
      if (n_exp < 16) exp_rec[n_exp] = (sgn << 9) | (cur_row << 7) | col;
      n_exp++;
   endtask

   task automatic send_eor();
      @(negedge clk);
      px_eor = 1'b1;
      idle(3);
      px_eor = 1'b0;
      idle(3);
      cur_row++;
   endtask

   task automatic start_frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      n_exp = 0;
      cur_row = 0;
   endtask

   task automatic read_rec(input int idx, output int val);
      int lo, hi;
      @(negedge clk); rd_addr = AW'(2*idx);
      @(negedge clk); lo = rd_data; rd_addr = AW'(2*idx + 1);
      @(negedge clk); hi = rd_data;
      val = (hi << 8) | lo;
   endtask

   task automatic check_store(input int n, input string req);
      int v;
      for (int i = 0; i < n; i++) begin
         read_rec(i, v);
         chk(v == exp_rec[i], req, v, exp_rec[i]);
      end
   endtask

   initial begin
      int d0, v;
      n_exp = 0; cur_row = 0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk(px_count == 0, "R8 reset count", int'(px_count), 0);
      chk(overflow == 0, "R8 reset overflow", int'(overflow), 0);
      chk(done == 0, "R4 reset done", int'(done), 0);

      // Frame A: pixels in rows 0,1,3, empty row 2; 5 pixels -> one full group + flush of 1
      start_frame();
      d0 = done_hits;
      send_px(1, 5, 3);
      send_px(0, 100, 3);
      send_eor();
      send_px(1, 127, 3);
      send_eor();
      send_eor();
      send_px(0, 0, 3);
      chk(px_count == 4, "R6 count mid-frame", int'(px_count), 4);
      send_px(1, 64, 3);
      chk(done_hits == d0, "R4 no early done", done_hits - d0, 0);
      send_eor();
      chk(done_hits == d0 + 1, "R4 single done pulse", done_hits - d0, 1);
      chk(px_count == 5, "R6 count frame A", int'(px_count), 5);
      check_store(5, "R1 R3 R5 record frame A");
      // R4: strobes after the end are ignored
      send_px(1, 9, 3);
      send_eor();
      chk(px_count == 5, "R4 ignored after done", int'(px_count), 5);
      chk(done_hits == d0 + 1, "R4 no second done", done_hits - d0, 1);
      read_rec(4, v);
      chk(v == exp_rec[4], "R4 store untouched", v, exp_rec[4]);
      n_exp = 5;

      // Frame B: held strobe, overflow, cleared by start
      start_frame();
      chk(px_count == 0, "R8 start clears count", int'(px_count), 0);
      d0 = done_hits;
      send_px(0, 33, 12); // R2 long strobe is one pixel
      chk(px_count == 1, "R2 held strobe one event", int'(px_count), 1);
      for (int i = 1; i < 8; i++) send_px(i & 1, 10 + 7*i, 3);
      chk(overflow == 0, "R7 no overflow at exactly full", int'(overflow), 0);
      send_px(1, 1, 3);
      send_px(0, 2, 3);
      chk(overflow == 1, "R7 overflow set", int'(overflow), 1);
      chk(px_count == 8, "R6 count saturates", int'(px_count), 8);
      for (int i = 0; i < 4; i++) send_eor();
      chk(done_hits == d0 + 1, "R4 done frame B", done_hits - d0, 1);
      chk(overflow == 1, "R7 overflow sticky", int'(overflow), 1);
      check_store(8, "R7 R9 first records kept");

      // Frame C: exact group in row 1, no flush needed
      start_frame();
      chk(overflow == 0, "R8 start clears overflow", int'(overflow), 0);
      d0 = done_hits;
      send_eor();
      for (int i = 0; i < 4; i++) send_px(i >> 1, 120 + i, 3);
      send_eor();
      send_eor();
      send_eor();
      chk(done_hits == d0 + 1, "R4 done frame C", done_hits - d0, 1);
      chk(px_count == 4, "R6 count frame C", int'(px_count), 4);
      check_store(4, "R3 R5 record frame C");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule